// File: doc/BRIEF.md
# Dual Parity XOR Accumulator

This block builds two parity blocks in one pass over four source streams, as needed by a two-dimensional (horizontal plus diagonal) parity scheme. After a start request it reads every 64-bit word of source 0, then source 1, then source 2, then source 3, and folds each word into on-chip result buffers as the word arrives. There are two buffers of 128 words each. Sources 0 and 1 go into both buffers. Source 2 goes only into the horizontal buffer, and source 3 only into the diagonal buffer. When the last word of source 3 has been taken in, the horizontal buffer is written out to its destination, then the diagonal buffer is written to its own destination. The block then pulses done.

Configuration is a set of plain inputs that are sampled when start is accepted: four source base addresses, two destination base addresses and a byte count. Memory traffic uses three valid/ready channels. The read request channel carries addresses out. The read response channel brings data back in request order. The write channel carries address and data together. On every channel a transfer happens on a rising edge where valid and ready are both high. A valid that has been raised keeps its payload steady until it is accepted. The block never lowers rrsp_ready partway through the read phase, so the memory side can pace responses freely. Requests may run ahead of responses by any number of words.

Top module: `dpx_accum`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, err, rreq_valid and wr_valid are all low, and they stay low until start is asserted.
- R2: A start seen while idle is rejected if cfg_bytes is zero, is not a multiple of 8, or is above 1024. On rejection err goes high in the next cycle, busy stays low and no request is issued. A valid start clears err in the next cycle and raises busy.
- R3: Read requests go out for source 0, then 1, then 2, then 3. Within each source they go to base + 8*k for k = 0 .. N-1, where N = cfg_bytes/8. A request that is not accepted keeps rreq_valid high and rreq_addr unchanged.
- R4: Horizontal word k equals src0[k] XOR src1[k] XOR src2[k]. Diagonal word k equals src0[k] XOR src1[k] XOR src3[k].
- R5: The first source stream overwrites the buffer entries, so contents left over from an earlier operation never appear in a result.
- R6: During the read phase rrsp_ready is high. A cycle without rrsp_valid changes neither the word index nor the buffers, so gaps in the responses have no effect on the results.
- R7: wr_valid rises only after all 4*N responses have been taken in. Horizontal word k goes to hdst + 8*k for k in ascending order, and then diagonal word k goes to ddst + 8*k. A write that is not accepted holds wr_addr and wr_data.
- R8: done is high for exactly one cycle, starting the cycle after the last diagonal write is accepted. busy is low in that same cycle.
- R9: A start that arrives while busy is ignored. The operation in progress finishes with its original configuration and err is unchanged.
- R10: A byte count of exactly 1024 (128 words per stream, filling both buffers) is accepted and produces correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, taken only while idle |
| cfg_src0 | input | 32 | Base address of source 0 (feeds both results) |
| cfg_src1 | input | 32 | Base address of source 1 (feeds both results) |
| cfg_src2 | input | 32 | Base address of source 2 (horizontal only) |
| cfg_src3 | input | 32 | Base address of source 3 (diagonal only) |
| cfg_hdst | input | 32 | Destination base of the horizontal result |
| cfg_ddst | input | 32 | Destination base of the diagonal result |
| cfg_bytes | input | 16 | Byte count per stream |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected for its byte count |
| rreq_valid | output | 1 | Read request valid |
| rreq_ready | input | 1 | Read request accepted |
| rreq_addr | output | 32 | Read request address |
| rrsp_valid | input | 1 | Read response valid |
| rrsp_ready | output | 1 | Block can take a read response |
| rrsp_data | input | 64 | Read response data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write address |
| wr_data | output | 64 | Write data |

## Verification
The assertions assume that responses come back in request order and that the memory side never returns more responses than were requested. They also assume that start is not held high across the cycle in which an operation completes. The bench memory model keeps to these rules: it queues one response for each accepted request and releases responses from the head of that queue. Every start in the bench is a single-cycle pulse. Ready and response-valid are drawn at random each cycle, so hold and stall behaviour is exercised, and the bench never violates the ordering the block relies on.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dpx_state_e;

  localparam int NUM_SRC  = 4;
  localparam int SRC_SEL_W = $clog2(NUM_SRC);
  localparam int NUM_LANE = 2;
endpackage

// File: rtl/dpx_read_seq.sv
module dpx_read_seq #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int OFS_W  = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      launch,
  input  logic                                      active,
  input  logic [IDX_W-1:0]                          last_idx,
  input  logic [dpx_pkg::NUM_SRC-1:0][ADDR_W-1:0]   src_base,
  output logic                                      rreq_valid,
  input  logic                                      rreq_ready,
  output logic [ADDR_W-1:0]                         rreq_addr,
  input  logic                                      rrsp_valid,
  output logic                                      rrsp_ready,
  output logic                                      acc_en,
  output logic [dpx_pkg::SRC_SEL_W-1:0]             acc_src,
  output logic [IDX_W-1:0]                          acc_idx,
  output logic                                      rd_last
);
  import dpx_pkg::*;

  localparam logic [SRC_SEL_W-1:0] LAST_SRC = SRC_SEL_W'(NUM_SRC - 1);

  logic [SRC_SEL_W-1:0] req_src_q, rsp_src_q;
  logic [IDX_W-1:0]     req_idx_q, rsp_idx_q;
  logic                 req_fin_q;
  logic                 req_xfer, rsp_xfer;

  assign rreq_valid = active && !req_fin_q;
  assign rreq_addr  = src_base[req_src_q] + ADDR_W'({req_idx_q, {OFS_W{1'b0}}});
  assign req_xfer   = rreq_valid && rreq_ready;

  assign rrsp_ready = active;
  assign rsp_xfer   = rrsp_valid && active;

  assign acc_en  = rsp_xfer;
  assign acc_src = rsp_src_q;
  assign acc_idx = rsp_idx_q;
  assign rd_last = rsp_xfer && (rsp_src_q == LAST_SRC) && (rsp_idx_q == last_idx);

  // request side walks source by source, word by word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_src_q <= '0;
      req_idx_q <= '0;
      req_fin_q <= 1'b0;
    end else if (launch) begin
      req_src_q <= '0;
      req_idx_q <= '0;
      req_fin_q <= 1'b0;
    end else if (req_xfer) begin
      if (req_idx_q == last_idx) begin
        req_idx_q <= '0;
        if (req_src_q == LAST_SRC) req_fin_q <= 1'b1;
        else                       req_src_q <= req_src_q + 1'b1;
      end else begin
        req_idx_q <= req_idx_q + 1'b1;
      end
    end
  end

  // response side follows the same order, responses arrive in order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_src_q <= '0;
      rsp_idx_q <= '0;
    end else if (launch) begin
      rsp_src_q <= '0;
      rsp_idx_q <= '0;
    end else if (rsp_xfer) begin
      if (rsp_idx_q == last_idx) begin
        rsp_idx_q <= '0;
        rsp_src_q <= rsp_src_q + 1'b1;
      end else begin
        rsp_idx_q <= rsp_idx_q + 1'b1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rreq_valid && !rreq_ready && !launch) |=> (rreq_valid && $stable(rreq_addr))); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rrsp_valid) |=> ($stable(rsp_idx_q) && $stable(rsp_src_q))); // R6
endmodule

// File: rtl/dpx_parity_lane.sv
module dpx_parity_lane #(
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 128,
  parameter int IDX_W   = 7,
  parameter int OWN_SRC = 2
) (
  input  logic                          clk,
  input  logic                          acc_en,
  input  logic [dpx_pkg::SRC_SEL_W-1:0] acc_src,
  input  logic [IDX_W-1:0]              acc_idx,
  input  logic [DATA_W-1:0]             acc_data,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [DATA_W-1:0]             rd_data
);
  import dpx_pkg::*;

  localparam logic [SRC_SEL_W-1:0] OWN_SEL = SRC_SEL_W'(OWN_SRC);

  logic [DATA_W-1:0] buf_q [DEPTH];

  // source 0 loads, source 1 and the lane's own source fold in, others skip
  always_ff @(posedge clk) begin
    if (acc_en) begin
      if (acc_src == '0)
        buf_q[acc_idx] <= acc_data;
      else if (acc_src == SRC_SEL_W'(1) || acc_src == OWN_SEL)
        buf_q[acc_idx] <= buf_q[acc_idx] ^ acc_data;
    end
  end

  assign rd_data = buf_q[rd_idx];
endmodule

// File: rtl/dpx_write_seq.sv
module dpx_write_seq #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int OFS_W  = 3
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           launch,
  input  logic                                           active,
  input  logic [IDX_W-1:0]                               last_idx,
  input  logic [ADDR_W-1:0]                              hdst,
  input  logic [ADDR_W-1:0]                              ddst,
  input  logic [dpx_pkg::NUM_LANE-1:0][DATA_W-1:0]       lane_data,
  output logic [IDX_W-1:0]                               rd_idx,
  output logic                                           wr_valid,
  input  logic                                           wr_ready,
  output logic [ADDR_W-1:0]                              wr_addr,
  output logic [DATA_W-1:0]                              wr_data,
  output logic                                           wr_last
);
  logic             lane_q;
  logic [IDX_W-1:0] idx_q;
  logic             xfer;

  assign wr_valid = active;
  assign rd_idx   = idx_q;
  assign wr_addr  = (lane_q ? ddst : hdst) + ADDR_W'({idx_q, {OFS_W{1'b0}}});
  assign wr_data  = lane_data[lane_q];
  assign xfer     = wr_valid && wr_ready;
  assign wr_last  = xfer && lane_q && (idx_q == last_idx);

  // horizontal lane first, then diagonal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= 1'b0;
      idx_q  <= '0;
    end else if (launch) begin
      lane_q <= 1'b0;
      idx_q  <= '0;
    end else if (xfer) begin
      if (idx_q == last_idx) begin
        idx_q  <= '0;
        lane_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7
endmodule

// File: rtl/dpx_accum.sv
module dpx_accum #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src0,
  input  logic [ADDR_W-1:0] cfg_src1,
  input  logic [ADDR_W-1:0] cfg_src2,
  input  logic [ADDR_W-1:0] cfg_src3,
  input  logic [ADDR_W-1:0] cfg_hdst,
  input  logic [ADDR_W-1:0] cfg_ddst,
  input  logic [CNT_W-1:0]  cfg_bytes,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rreq_valid,
  input  logic              rreq_ready,
  output logic [ADDR_W-1:0] rreq_addr,
  input  logic              rrsp_valid,
  output logic              rrsp_ready,
  input  logic [DATA_W-1:0] rrsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import dpx_pkg::*;

  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int OFS_W          = $clog2(BYTES_PER_WORD);
  localparam int IDX_W          = $clog2(DEPTH);
  localparam int MAX_BYTES      = DEPTH * BYTES_PER_WORD;

  dpx_state_e state_q;
  logic [NUM_SRC-1:0][ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] hdst_q, ddst_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic              err_q, done_q;

  logic              bad_cnt, accept, launch;
  logic [CNT_W-1:0]  nwords_m1;
  logic              rd_last, wr_last;
  logic              acc_en;
  logic [SRC_SEL_W-1:0] acc_src;
  logic [IDX_W-1:0]  acc_idx, rd_idx;
  logic [NUM_LANE-1:0][DATA_W-1:0] lane_rd;

  assign bad_cnt   = (cfg_bytes == '0) || (cfg_bytes[OFS_W-1:0] != '0) ||
                     (int'(cfg_bytes) > MAX_BYTES);
  assign accept    = (state_q == ST_IDLE) && start;
  assign launch    = accept && !bad_cnt;
  assign nwords_m1 = (cfg_bytes >> OFS_W) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      src_q      <= '0;
      hdst_q     <= '0;
      ddst_q     <= '0;
      last_idx_q <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            err_q <= bad_cnt;
            if (!bad_cnt) begin
              state_q    <= ST_READ;
              src_q      <= {cfg_src3, cfg_src2, cfg_src1, cfg_src0};
              hdst_q     <= cfg_hdst;
              ddst_q     <= cfg_ddst;
              last_idx_q <= nwords_m1[IDX_W-1:0];
            end
          end
        end
        ST_READ:  if (rd_last) state_q <= ST_WRITE;
        ST_WRITE: if (wr_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

  dpx_read_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .launch(launch), .active(state_q == ST_READ),
    .last_idx(last_idx_q), .src_base(src_q),
    .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_addr(rreq_addr),
    .rrsp_valid(rrsp_valid), .rrsp_ready(rrsp_ready),
    .acc_en(acc_en), .acc_src(acc_src), .acc_idx(acc_idx), .rd_last(rd_last)
  );

  // lane 0 horizontal (own source 2), lane 1 diagonal (own source 3)
  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    dpx_parity_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .OWN_SRC(2 + g)) u_lane (
      .clk(clk), .acc_en(acc_en), .acc_src(acc_src), .acc_idx(acc_idx),
      .acc_data(rrsp_data), .rd_idx(rd_idx), .rd_data(lane_rd[g])
    );
  end

  dpx_write_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .active(state_q == ST_WRITE),
    .last_idx(last_idx_q), .hdst(hdst_q), .ddst(ddst_q), .lane_data(lane_rd),
    .rd_idx(rd_idx), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last)
  );

  AST_BAD_CNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && bad_cnt) |=> (!busy && err && !rreq_valid)); // R2
  AST_GOOD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !bad_cnt) |=> (busy && !err)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_valid)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(err)); // R9
endmodule

// File: tb/dpx_accum_tb.sv
module dpx_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_src0 = '0, cfg_src1 = '0, cfg_src2 = '0, cfg_src3 = '0;
  logic [31:0] cfg_hdst = '0, cfg_ddst = '0;
  logic [15:0] cfg_bytes = '0;
  logic        busy, done, err;
  logic        rreq_valid, rrsp_ready, wr_valid;
  logic        rreq_ready = 1'b0, rrsp_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] rreq_addr, wr_addr;
  logic [63:0] rrsp_data = '0, wr_data;

  always #5 clk = ~clk;

  dpx_accum dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src0(cfg_src0), .cfg_src1(cfg_src1), .cfg_src2(cfg_src2), .cfg_src3(cfg_src3),
    .cfg_hdst(cfg_hdst), .cfg_ddst(cfg_ddst), .cfg_bytes(cfg_bytes),
    .busy(busy), .done(done), .err(err),
    .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_addr(rreq_addr),
    .rrsp_valid(rrsp_valid), .rrsp_ready(rrsp_ready), .rrsp_data(rrsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_err = 0;
  int req_pct = 100, rsp_pct = 100, wr_pct = 100;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] exp_req [512];
  logic [31:0] exp_wa  [256];
  logic [63:0] exp_wd  [256];
  int exp_req_n = 0, exp_wr_n = 0;
  int req_cnt = 0, rsp_cnt = 0, wr_cnt = 0;
  logic [63:0] rsp_q [$];
  logic        prev_req_stall = 1'b0;
  logic [31:0] prev_req_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] word_at(input logic [31:0] a);
    return {a ^ seed, (a * 32'h9E37_79B1) ^ ~seed};
  endfunction

  // memory model: one call per falling edge
  task automatic mem_step();
    rreq_ready = ($urandom_range(0, 99) < req_pct);
    wr_ready   = ($urandom_range(0, 99) < wr_pct);
    if (rsp_q.size() > 0 && $urandom_range(0, 99) < rsp_pct) begin
      rrsp_valid = 1'b1;
      rrsp_data  = rsp_q[0];
    end else begin
      rrsp_valid = 1'b0;
      rrsp_data  = '0;
    end
    #1;
    if (prev_req_stall)
      chk(rreq_valid && rreq_addr == prev_req_addr, "R3", "stalled request held",
          {32'd0, rreq_addr}, {32'd0, prev_req_addr});
    if (rreq_valid && rreq_ready) begin
      if (req_cnt >= exp_req_n)
        chk(1'b0, "R2/R3", "unexpected read request", {32'd0, rreq_addr}, 64'd0);
      else
        chk(rreq_addr == exp_req[req_cnt], "R3", "read request address",
            {32'd0, rreq_addr}, {32'd0, exp_req[req_cnt]});
      rsp_q.push_back(word_at(rreq_addr));
      req_cnt++;
    end
    prev_req_stall = rreq_valid && !rreq_ready;
    prev_req_addr  = rreq_addr;
    if (rrsp_valid && rrsp_ready) begin
      void'(rsp_q.pop_front());
      rsp_cnt++;
    end
    if (wr_valid && rsp_cnt < exp_req_n)
      chk(1'b0, "R7", "write before reads complete", 64'(rsp_cnt), 64'(exp_req_n));
    if (wr_valid && wr_ready) begin
      if (wr_cnt >= exp_wr_n) begin
        chk(1'b0, "R7", "unexpected write", {32'd0, wr_addr}, 64'd0);
      end else begin
        chk(wr_addr == exp_wa[wr_cnt], "R7", "write address",
            {32'd0, wr_addr}, {32'd0, exp_wa[wr_cnt]});
        chk(wr_data == exp_wd[wr_cnt], "R4/R5", "parity word",
            wr_data, exp_wd[wr_cnt]);
      end
      wr_cnt++;
    end
  endtask

  initial forever begin
    @(negedge clk);
    mem_step();
  end

  task automatic prepare(input logic [31:0] s0, s1, s2, s3, hd, dd, input int bytes);
    int n;
    logic [31:0] s [4];
    n = bytes / 8;
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < n; k++) exp_req[j * n + k] = s[j] + 32'(8 * k);
    for (int k = 0; k < n; k++) begin
      logic [63:0] base;
      base = word_at(s0 + 32'(8 * k)) ^ word_at(s1 + 32'(8 * k));
      exp_wa[k]     = hd + 32'(8 * k);
      exp_wd[k]     = base ^ word_at(s2 + 32'(8 * k));
      exp_wa[n + k] = dd + 32'(8 * k);
      exp_wd[n + k] = base ^ word_at(s3 + 32'(8 * k));
    end
    exp_req_n = 4 * n;
    exp_wr_n  = 2 * n;
    req_cnt = 0; rsp_cnt = 0; wr_cnt = 0;
    cfg_src0 = s0; cfg_src1 = s1; cfg_src2 = s2; cfg_src3 = s3;
    cfg_hdst = hd; cfg_ddst = dd; cfg_bytes = 16'(bytes);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_finish(input string tag);
    wait (wr_cnt == exp_wr_n);
    @(negedge clk); #2;
    chk(done && !busy, "R8", {tag, " done pulse"}, {62'd0, done, busy}, 64'd2);
    @(negedge clk); #2;
    chk(!done, "R8", {tag, " done one cycle"}, {63'd0, done}, 64'd0);
    chk(rsp_cnt == exp_req_n && req_cnt == exp_req_n, "R3", {tag, " read count"},
        64'(rsp_cnt), 64'(exp_req_n));
    exp_req_n = 0; exp_wr_n = 0;
  endtask

  task automatic t_reset();
    #2;
    chk(!busy && !done && !err && !rreq_valid && !wr_valid, "R1", "outputs in reset",
        {59'd0, busy, done, err, rreq_valid, wr_valid}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !done && !err && !rreq_valid && !wr_valid, "R1", "outputs after reset",
        {59'd0, busy, done, err, rreq_valid, wr_valid}, 64'd0);
  endtask

  task automatic t_full_block();
    seed = 32'hA5A5_0F0F;
    req_pct = 60; rsp_pct = 60; wr_pct = 60;
    prepare(32'hA000_0400, 32'hA000_0800, 32'hA000_0C00, 32'hA000_1000,
            32'hB000_0400, 32'hB000_0800, 1024);
    pulse_start();
    #2;
    chk(busy && !err, "R10", "full block accepted", {62'd0, busy, err}, 64'd2);
    wait_finish("R10 full");
  endtask

  task automatic t_small_stalled();
    seed = 32'h0BAD_F00D;
    req_pct = 30; rsp_pct = 20; wr_pct = 30;
    prepare(32'h1000_0000, 32'h2000_0040, 32'h3000_0080, 32'h4000_00C0,
            32'h5000_0000, 32'h6000_0100, 64);
    pulse_start();
    wait_finish("R6 stalled / R5 fresh");
  endtask

  task automatic t_bad_counts();
    int bad [3];
    bad[0] = 0; bad[1] = 12; bad[2] = 1032;
    req_pct = 100; rsp_pct = 100; wr_pct = 100;
    foreach (bad[i]) begin
      prepare(32'h100, 32'h200, 32'h300, 32'h400, 32'h500, 32'h600, 0);
      cfg_bytes = 16'(bad[i]);
      pulse_start();
      #2;
      chk(err && !busy, "R2", "bad count rejected", {62'd0, err, busy}, 64'd2);
      repeat (6) @(negedge clk);
      #2;
      chk(!busy && !rreq_valid && req_cnt == 0, "R2", "no activity after reject",
          64'(req_cnt), 64'd0);
    end
    seed = 32'h7777_1111;
    prepare(32'h800, 32'h900, 32'hA00, 32'hB00, 32'hC00, 32'hD00, 8);
    pulse_start();
    #2;
    chk(!err && busy, "R2", "valid start clears err", {62'd0, err, busy}, 64'd1);
    wait_finish("R2 single word");
  endtask

  task automatic t_start_while_busy();
    seed = 32'h5EED_CAFE;
    req_pct = 70; rsp_pct = 50; wr_pct = 50;
    prepare(32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 32'h0004_0000,
            32'h0005_0000, 32'h0006_0000, 256);
    pulse_start();
    wait (req_cnt >= 20);
    @(negedge clk);
    cfg_bytes = 16'd12;
    cfg_src0  = 32'hDEAD_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_bytes = 16'd256;
    @(negedge clk); #2;
    chk(busy && !err, "R9", "start while busy ignored", {62'd0, busy, err}, 64'd2);
    wait_finish("R9 busy start");
    chk(!err, "R9", "err untouched", {63'd0, err}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_full_block();
    t_small_stalled();
    t_bad_counts();
    t_start_while_busy();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule